// File: doc/BRIEF.md
# Dual-Counter Compare/Capture Timer

This block produces operating-system ticks and DMA triggers from two independent 64-bit time bases. Each time base is a 32-bit prescale stage that wraps at a programmable limit and a 32-bit free-running count that steps on every wrap. Four compare units each watch the free-running count of one of the two time bases, chosen per unit.

When a compare unit's value equals the count, it raises its flag and then adds its own update amount to the compare value. The next tick therefore comes with no software action. A flag drives an interrupt line, or a single-cycle DMA strobe when the unit is in DMA mode.

Each time base has a capture input that timestamps an outside event. A word-addressed register port with separate read and write strobes controls the whole block. Reading the upper half of a count or a capture freezes the matching lower half in a shadow, so a 64-bit value can be read over two 32-bit accesses without tearing.

Top module: `tmr_core`

## Requirements
- R1: After reset, every register reads zero. `irq_o` and `dma_o` are low, and both time bases are stopped.
- R2: Word 0x00 holds a run bit for each time base: bit 0 is time base 0 and bit 1 is time base 1. While a time base runs, on each clock its prescale value steps by one. When the prescale value is at or above the limit, it returns to 0 and the free-running count steps by one. A stopped time base holds both values.
- R3: Time base k occupies words 0x08+8k upward:
  - +0 is the free-running count.
  - +1 is the prescale value.
  - +2 is the limit.
  - +3 is the captured count.
  - +4 is the captured prescale value.

  A read of +0 latches the live prescale value. A later read of +1 returns that latched value.
- R4: A high `cap_i[k]` at a clock edge stores the free-running count and the prescale value of time base k. A read of +3 latches the captured prescale value, and a later read of +4 returns it.
- R5: Compare unit j occupies words 0x20+4j upward: +0 is the compare value, +1 is the update amount, +2 is the configuration. While the selected time base runs and its free-running count equals the compare value, the flag of unit j sets on the next edge. On that same edge, the compare value grows by the update amount.
- R6: Configuration bit 0 selects the source time base of the unit (0 or 1). A stopped source produces no match.
- R7: A write to word 0x01 sets the enable bits that are written as one. A write to word 0x02 clears them. Bits written as zero are unchanged. Both words read back the four enable bits.
- R8: Word 0x03 reads the four flags. Writing a one clears that flag, and writing a zero has no effect. A match in the same cycle keeps the flag set.
- R9: `irq_o[j]` is high exactly while flag j and enable j are set and unit j is not in DMA mode.
- R10: With configuration bit 1 set (DMA mode), each match while enabled gives a one-cycle pulse on `dma_o[j]` one edge later, and `irq_o[j]` stays low.
- R11: A register write takes precedence over counting and over the automatic advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, drives the shadow latches |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cap_i | input | 2 | Capture event per time base |
| irq_o | output | 4 | Interrupt request per compare unit |
| dma_o | output | 4 | DMA strobe per compare unit |

## Verification
- **Writes and counts:** A write is visible in `rdata` one edge after its strobe. A running time base with a zero limit shows its new count one edge later. So a read placed one cycle after a write to the count register expects the written value plus one.
- **Compare and DMA outputs:** A count that reaches the compare value on edge n sets the flag and `irq_o` on edge n+1. The DMA pulse appears on that same edge n+1. The bench samples at falling edges, four and five falling edges after the start write, to check both sides of that edge.
- **Shadow reads:** A shadow value is taken on the edge that ends the upper-half read, so the bench reads the lower half on a later access. It checks the lower half against the count the upper half had, never against the live count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Word addresses of the shared control registers
    localparam int ADR_CTRL   = 0;
    localparam int ADR_EN_SET = 1;
    localparam int ADR_EN_CLR = 2;
    localparam int ADR_FLAG   = 3;

    // Time base register window
    localparam int CNT_BASE   = 8;
    localparam int CNT_STRIDE = 8;
    localparam int CNT_FRC    = 0;
    localparam int CNT_PRE    = 1;
    localparam int CNT_LIM    = 2;
    localparam int CNT_CAPHI  = 3;
    localparam int CNT_CAPLO  = 4;

    // Compare unit register window
    localparam int CMP_BASE   = 32;
    localparam int CMP_STRIDE = 4;
    localparam int CMP_VAL    = 0;
    localparam int CMP_UPD    = 1;
    localparam int CMP_CFG    = 2;

    function automatic int cnt_adr(input int idx, input int off);
        return CNT_BASE + CNT_STRIDE * idx + off;
    endfunction

    function automatic int cmp_adr(input int idx, input int off);
        return CMP_BASE + CMP_STRIDE * idx + off;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cap,
    input  logic          wr_frc,
    input  logic          wr_pre,
    input  logic          wr_lim,
    input  logic          rd_frc,
    input  logic          rd_cap,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] frc_o,
    output logic [DW-1:0] lim_o,
    output logic [DW-1:0] pre_sh_o,
    output logic [DW-1:0] cap_hi_o,
    output logic [DW-1:0] cap_sh_o
);

    localparam logic [DW-1:0] ONE = 1;

    typedef struct packed {
        logic [DW-1:0] pre;
        logic [DW-1:0] frc;
        logic [DW-1:0] lim;
        logic [DW-1:0] pre_sh;
        logic [DW-1:0] cap_hi;
        logic [DW-1:0] cap_lo;
        logic [DW-1:0] cap_sh;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // prescale stage feeding the free-running half
        if (run) begin
            if (st_q.pre >= st_q.lim) begin
                st_d.pre = '0;
                st_d.frc = st_q.frc + ONE;
            end else begin
                st_d.pre = st_q.pre + ONE;
            end
        end
        // register writes win over counting
        if (wr_frc) st_d.frc = wdata;
        if (wr_pre) st_d.pre = wdata;
        if (wr_lim) st_d.lim = wdata;
        // timestamp of the outside event
        if (cap) begin
            st_d.cap_hi = st_q.frc;
            st_d.cap_lo = st_q.pre;
        end
        // freeze lower halves when the upper half is read
        if (rd_frc) st_d.pre_sh = st_q.pre;
        if (rd_cap) st_d.cap_sh = st_q.cap_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frc_o    = st_q.frc;
    assign lim_o    = st_q.lim;
    assign pre_sh_o = st_q.pre_sh;
    assign cap_hi_o = st_q.cap_hi;
    assign cap_sh_o = st_q.cap_sh;

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int DW    = 32,
    parameter int SRC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    src_cnt,
    input  logic             src_run,
    input  logic             wr_cmp,
    input  logic             wr_upd,
    input  logic             wr_cfg,
    input  logic [DW-1:0]    wdata,
    input  logic [SRC_W:0]   cfg_wdata,
    output logic             match_o,
    output logic [DW-1:0]    cmp_o,
    output logic [DW-1:0]    upd_o,
    output logic [SRC_W-1:0] src_o,
    output logic             dma_mode_o
);

    typedef struct packed {
        logic [DW-1:0]    cmp;
        logic [DW-1:0]    upd;
        logic [SRC_W-1:0] src;
        logic             dma;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit  = src_run && (src_cnt == st_q.cmp);
        st_d = st_q;
        if (hit)    st_d.cmp = st_q.cmp + st_q.upd;
        if (wr_cmp) st_d.cmp = wdata;
        if (wr_upd) st_d.upd = wdata;
        if (wr_cfg) begin
            st_d.src = cfg_wdata[SRC_W-1:0];
            st_d.dma = cfg_wdata[SRC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_o    = hit;
    assign cmp_o      = st_q.cmp;
    assign upd_o      = st_q.upd;
    assign src_o      = st_q.src;
    assign dma_mode_o = st_q.dma;

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int N_CNT = 2,
    parameter int N_CMP = 4,
    parameter int DW    = 32,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [N_CNT-1:0] cap_i,
    output logic [N_CMP-1:0] irq_o,
    output logic [N_CMP-1:0] dma_o
);

    import tmr_pkg::*;

    localparam int SRC_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;

    typedef struct packed {
        logic [N_CNT-1:0] run;
        logic [N_CMP-1:0] en;
        logic [N_CMP-1:0] flag;
        logic [N_CMP-1:0] dma;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [N_CNT-1:0]          wr_frc, wr_pre, wr_lim, rd_frc, rd_cap;
    logic [N_CMP-1:0]          wr_cmp, wr_upd, wr_cfg;
    logic [N_CNT-1:0][DW-1:0]  frc_w, lim_w, pre_sh_w, cap_hi_w, cap_sh_w;
    logic [N_CMP-1:0][DW-1:0]  cmp_w, upd_w, src_cnt;
    logic [N_CMP-1:0][SRC_W-1:0] src_w;
    logic [N_CMP-1:0]          src_run, match_w, dma_mode_w;

    // address decode of per-instance strobes
    always_comb begin
        for (int k = 0; k < N_CNT; k++) begin
            wr_frc[k] = wr_en && (addr == AW'(cnt_adr(k, CNT_FRC)));
            wr_pre[k] = wr_en && (addr == AW'(cnt_adr(k, CNT_PRE)));
            wr_lim[k] = wr_en && (addr == AW'(cnt_adr(k, CNT_LIM)));
            rd_frc[k] = rd_en && (addr == AW'(cnt_adr(k, CNT_FRC)));
            rd_cap[k] = rd_en && (addr == AW'(cnt_adr(k, CNT_CAPHI)));
        end
        for (int j = 0; j < N_CMP; j++) begin
            wr_cmp[j] = wr_en && (addr == AW'(cmp_adr(j, CMP_VAL)));
            wr_upd[j] = wr_en && (addr == AW'(cmp_adr(j, CMP_UPD)));
            wr_cfg[j] = wr_en && (addr == AW'(cmp_adr(j, CMP_CFG)));
        end
    end

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        tmr_counter #(.DW(DW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (st_q.run[k]),
            .cap      (cap_i[k]),
            .wr_frc   (wr_frc[k]),
            .wr_pre   (wr_pre[k]),
            .wr_lim   (wr_lim[k]),
            .rd_frc   (rd_frc[k]),
            .rd_cap   (rd_cap[k]),
            .wdata    (wdata),
            .frc_o    (frc_w[k]),
            .lim_o    (lim_w[k]),
            .pre_sh_o (pre_sh_w[k]),
            .cap_hi_o (cap_hi_w[k]),
            .cap_sh_o (cap_sh_w[k])
        );
    end

    // each compare unit picks its time base
    always_comb begin
        for (int j = 0; j < N_CMP; j++) begin
            src_cnt[j] = frc_w[src_w[j]];
            src_run[j] = st_q.run[src_w[j]];
        end
    end

    for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
        tmr_compare #(.DW(DW), .SRC_W(SRC_W)) u_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_cnt    (src_cnt[j]),
            .src_run    (src_run[j]),
            .wr_cmp     (wr_cmp[j]),
            .wr_upd     (wr_upd[j]),
            .wr_cfg     (wr_cfg[j]),
            .wdata      (wdata),
            .cfg_wdata  (wdata[SRC_W:0]),
            .match_o    (match_w[j]),
            .cmp_o      (cmp_w[j]),
            .upd_o      (upd_w[j]),
            .src_o      (src_w[j]),
            .dma_mode_o (dma_mode_w[j])
        );
    end

    // shared control state
    always_comb begin
        st_d = st_q;
        if (wr_en && addr == AW'(ADR_CTRL))   st_d.run = wdata[N_CNT-1:0];
        if (wr_en && addr == AW'(ADR_EN_SET)) st_d.en  = st_q.en | wdata[N_CMP-1:0];
        if (wr_en && addr == AW'(ADR_EN_CLR)) st_d.en  = st_q.en & ~wdata[N_CMP-1:0];
        if (wr_en && addr == AW'(ADR_FLAG))   st_d.flag = st_q.flag & ~wdata[N_CMP-1:0];
        st_d.flag = st_d.flag | match_w;
        st_d.dma  = match_w & st_q.en & dma_mode_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.flag & st_q.en & ~dma_mode_w;
    assign dma_o = st_q.dma;

    // read mux
    always_comb begin
        rdata = '0;
        if (addr == AW'(ADR_CTRL)) rdata[N_CNT-1:0] = st_q.run;
        if (addr == AW'(ADR_EN_SET) || addr == AW'(ADR_EN_CLR)) rdata[N_CMP-1:0] = st_q.en;
        if (addr == AW'(ADR_FLAG)) rdata[N_CMP-1:0] = st_q.flag;
        for (int k = 0; k < N_CNT; k++) begin
            if (addr == AW'(cnt_adr(k, CNT_FRC)))   rdata = frc_w[k];
            if (addr == AW'(cnt_adr(k, CNT_PRE)))   rdata = pre_sh_w[k];
            if (addr == AW'(cnt_adr(k, CNT_LIM)))   rdata = lim_w[k];
            if (addr == AW'(cnt_adr(k, CNT_CAPHI))) rdata = cap_hi_w[k];
            if (addr == AW'(cnt_adr(k, CNT_CAPLO))) rdata = cap_sh_w[k];
        end
        for (int j = 0; j < N_CMP; j++) begin
            if (addr == AW'(cmp_adr(j, CMP_VAL))) rdata = cmp_w[j];
            if (addr == AW'(cmp_adr(j, CMP_UPD))) rdata = upd_w[j];
            if (addr == AW'(cmp_adr(j, CMP_CFG))) rdata[SRC_W:0] = {dma_mode_w[j], src_w[j]};
        end
    end

endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
    parameter int N_CNT = 2,
    parameter int N_CMP = 4,
    parameter int DW    = 32,
    parameter int AW    = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [AW-1:0]            addr,
    input logic [DW-1:0]            wdata,
    input logic [N_CNT-1:0]         cap_i,
    input logic [N_CNT-1:0][DW-1:0] frc,
    input logic [N_CNT-1:0][DW-1:0] cap_hi,
    input logic [N_CMP-1:0][DW-1:0] cmp,
    input logic [N_CMP-1:0][DW-1:0] upd,
    input logic [N_CMP-1:0]         match,
    input logic [N_CMP-1:0]         flag,
    input logic [N_CMP-1:0]         en
);

    import tmr_pkg::*;

    localparam logic [DW-1:0] ONE = 1;

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt_chk
        // R2: without a write the count holds or steps by one
        a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (frc[k] == $past(frc[k]) || frc[k] == $past(frc[k]) + ONE));
        // R4: a capture event stores the count seen at that edge
        a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
            cap_i[k] |=> cap_hi[k] == $past(frc[k]));
    end

    for (genvar j = 0; j < N_CMP; j++) begin : g_cmp_chk
        localparam logic [AW-1:0] CMP_A = AW'(cmp_adr(j, CMP_VAL));
        // R5: a match advances the compare value by the update amount
        a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
            (match[j] && !(wr_en && addr == CMP_A)) |=> cmp[j] == $past(cmp[j]) + $past(upd[j]));
    end

    // R8: write-one clears a flag unless a match lands in the same cycle
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(ADR_FLAG)) |=> (flag & $past(wdata[N_CMP-1:0] & ~match)) == '0);
    a_r8_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |=> (flag & $past(match)) == $past(match));
    // R7: set and clear words touch only the bits written as one
    a_r7_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(ADR_EN_SET)) |=> (en & $past(wdata[N_CMP-1:0])) == $past(wdata[N_CMP-1:0]));
    a_r7_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(ADR_EN_CLR)) |=> (en & $past(wdata[N_CMP-1:0])) == '0);

endmodule

bind tmr_core tmr_core_chk #(
    .N_CNT(N_CNT), .N_CMP(N_CMP), .DW(DW), .AW(AW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .cap_i  (cap_i),
    .frc    (frc_w),
    .cap_hi (cap_hi_w),
    .cmp    (cmp_w),
    .upd    (upd_w),
    .match  (match_w),
    .flag   (st_q.flag),
    .en     (st_q.en)
);

// File: tb/tmr_core_test.sv
`timescale 1ns/100ps
module tmr_core_test;

    localparam int A_CTRL = 0, A_ENS = 1, A_ENC = 2, A_FLAG = 3;
    localparam int A_FRC0 = 8,  A_PRE0 = 9,  A_LIM0 = 10, A_CH0 = 11, A_CL0 = 12;
    localparam int A_FRC1 = 16, A_LIM1 = 18;
    localparam int A_CMP0 = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  cap_i = '0;
    logic [3:0]  irq_o, dma_o;

    int n_chk = 0;
    int n_err = 0;
    int dma_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cap_i(cap_i), .irq_o(irq_o), .dma_o(dma_o)
    );

    always @(negedge clk) if (dma_o[2]) dma_cnt++;

    function automatic int cmp_addr(input int j, input int off);
        return A_CMP0 + 4 * j + off;
    endfunction

    // smallest base + upd*m that is not below f
    function automatic logic [31:0] next_cmp(input logic [31:0] base, input logic [31:0] upd,
                                             input logic [31:0] f);
        if (f <= base) return base;
        return base + upd * ((f - base + upd - 1) / upd);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 6'(a);
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] v, p, h1, l1, h2, l2, f, m1, m2;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {28'd0, irq_o}, 32'd0);
        check("R1 dma", {28'd0, dma_o}, 32'd0);
        rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
        rd(A_ENS, v);  check("R1 enable", v, 32'd0);
        rd(A_FLAG, v); check("R1 flag", v, 32'd0);
        rd(A_FRC0, v); check("R1 count", v, 32'd0);

        // R2 random limits and run lengths
        for (int i = 0; i < 6; i++) begin
            int lim = int'($urandom % 6);
            int n   = int'($urandom % 20);
            wr(A_FRC0, 0); wr(A_PRE0, 0); wr(A_LIM0, 32'(lim));
            wr(A_CTRL, 1);
            repeat (n) @(negedge clk);
            wr(A_CTRL, 0);
            rd(A_FRC0, v); check("R2 count", v, 32'((n + 2) / (lim + 1)));
            rd(A_PRE0, v); check("R2 prescale", v, 32'((n + 2) % (lim + 1)));
        end

        // R3 coherent split read while running, limit 3
        wr(A_LIM0, 3); wr(A_FRC0, 0); wr(A_PRE0, 0);
        wr(A_CTRL, 1);
        repeat (5) @(negedge clk);
        rd(A_FRC0, h1); rd(A_PRE0, l1);
        rd(A_FRC0, h2); rd(A_PRE0, l2);
        check("R3 first read", h1 * 4 + l1, 32'd6);
        check("R3 second read", h2 * 4 + l2, 32'd10);
        wr(A_CTRL, 0);

        // R11 write beats counting
        wr(A_LIM0, 0); wr(A_CTRL, 1);
        wr(A_FRC0, 1000);
        rd(A_FRC0, v); check("R11 write precedence", v, 32'd1001);
        wr(A_CTRL, 0);

        // R4 capture of random timestamps
        wr(A_LIM0, 7);
        for (int i = 0; i < 3; i++) begin
            logic [31:0] cv = $urandom;
            logic [31:0] cp = $urandom % 8;
            wr(A_FRC0, cv); wr(A_PRE0, cp);
            @(negedge clk); cap_i[0] = 1'b1;
            @(negedge clk); cap_i[0] = 1'b0;
            wr(A_FRC0, cv + 5);
            rd(A_CH0, v); check("R4 capture count", v, cv);
            rd(A_CL0, v); check("R4 capture prescale", v, cp);
        end

        // R5/R9 match timing and advance
        wr(A_LIM0, 0); wr(A_PRE0, 0); wr(A_FRC0, 7);
        wr(cmp_addr(0, 0), 10); wr(cmp_addr(0, 1), 5); wr(cmp_addr(0, 2), 0);
        wr(A_FLAG, 32'hF); wr(A_ENS, 1);
        wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        check("R5 flag not yet", {31'd0, irq_o[0]}, 32'd0);
        @(negedge clk);
        check("R5 flag one edge after match", {31'd0, irq_o[0]}, 32'd1);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_FRC0, f);
        rd(cmp_addr(0, 0), v); check("R5 compare advance", v, next_cmp(32'd10, 32'd5, f));

        // R8 write-one clear, zeros ignored
        wr(A_FLAG, 32'hE);
        rd(A_FLAG, v); check("R8 zero write keeps flag", {31'd0, v[0]}, 32'd1);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v); check("R8 one write clears", {31'd0, v[0]}, 32'd0);
        check("R8 irq after clear", {31'd0, irq_o[0]}, 32'd0);

        // R9 enable gating
        wr(A_CTRL, 1);
        repeat (12) @(negedge clk);
        wr(A_CTRL, 0);
        wr(A_ENC, 1);
        check("R9 irq disabled", {31'd0, irq_o[0]}, 32'd0);
        wr(A_ENS, 1);
        check("R9 irq enabled", {31'd0, irq_o[0]}, 32'd1);

        // R7 random set/clear masks
        for (int i = 0; i < 4; i++) begin
            logic [31:0] cur;
            rd(A_ENS, cur);
            m1 = $urandom & 32'hF;
            m2 = $urandom & 32'hF;
            wr(A_ENS, m1);
            wr(A_ENC, m2);
            rd(A_ENC, v); check("R7 enable set/clear", v, (cur | m1) & ~m2 & 32'hF);
        end
        wr(A_ENC, 32'hF);

        // R6 source selection
        wr(A_FLAG, 32'hF);
        wr(A_LIM1, 0); wr(A_FRC1, 0);
        wr(cmp_addr(1, 0), 20); wr(cmp_addr(1, 1), 100); wr(cmp_addr(1, 2), 1);
        wr(cmp_addr(3, 0), 20); wr(cmp_addr(3, 1), 100); wr(cmp_addr(3, 2), 0);
        wr(A_ENS, 32'hA);
        wr(A_CTRL, 2);
        repeat (30) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_FLAG, v); check("R6 only unit on time base 1 fires", v, 32'h2);
        check("R6 irq lines", {28'd0, irq_o}, 32'h2);

        // R10 DMA mode
        wr(A_FLAG, 32'hF); wr(A_FRC1, 0);
        wr(cmp_addr(2, 0), 4); wr(cmp_addr(2, 1), 3); wr(cmp_addr(2, 2), 3);
        wr(A_ENS, 32'h4);
        dma_cnt = 0;
        wr(A_CTRL, 2);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_FRC1, f); check("R2 time base 1 count", f, 32'd22);
        check("R10 dma pulse count", 32'(dma_cnt), (f - 1 - 4) / 3 + 1);
        rd(A_FLAG, v); check("R10 flag set", {31'd0, v[2]}, 32'd1);
        check("R10 irq stays low", {31'd0, irq_o[2]}, 32'd0);

        finish_run();
    end

endmodule